// File: doc/BRIEF.md
# Clock-Stop Power State Controller

This block decides when a processor core may sit with its clocks stopped, and what happens to the work that arrives in the meantime. A system-level stop-clock request moves the core from its running state into a granted low-power state. The core stays there until the request is withdrawn. While the core is stopped, the block still lets bus snoops and bus-delivered interrupts be handled. It does this by detouring through a short snoop-service state, which it leaves only when the matching handshakes come back.

Sideband events arrive on five lines: a management interrupt, a soft initialise, a bus initialise and two local interrupt lines. While the core is stopped, the block holds these events in latches and does not act on them. When the core runs again, each held event type is released as one service pulse, however many times it was asserted. A core-reset request starts a core initialise at once but does not move the power state. While the core is stopped, a wake-request output tells system logic that something is waiting. This output is driven even when the waiting interrupt is one the core currently has masked.

Top module: `clkstop_pwr_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the state at RUN (code 0) and clears every event latch and the held bus interrupt, so `svc_o`, `bus_irq_svc_o`, `core_init_o` and `wake_o` are all low after it.
- R2: From RUN with `clk_stop_req` high at a clock edge, `state_o` becomes GRANT (code 1) after that edge. From GRANT with `clk_stop_req` low, the state returns to RUN. This exit takes priority over any snoop or interrupt request seen in the same cycle.
- R3: In GRANT with `clk_stop_req` high, a `snoop_req` or `irq_txn_req` moves the state to SNOOP (code 2). SNOOP keeps a record of which kinds were requested. It returns to GRANT only when each recorded kind has been answered: `snoop_done` for a snoop and `irq_captured` for an interrupt transaction.
- R4: A rising `core_rst_req` gives a `core_init_o` pulse exactly one cycle wide, in the cycle after the edge where the rise is seen. `state_o` does not change because of it.
- R5: `evt_in` bits are latched in any state. The bit positions are: 0 management interrupt, 1 soft initialise, 2 bus initialise, 3 local line 0, 4 local line 1. While the state is not RUN, `svc_o` stays all zero, and this includes the bus-initialise bit.
- R6: In the first cycle in which `state_o` reads RUN, `svc_o` shows every held event bit. Each bit pulses once, whatever number of assertions was collected, and then clears.
- R7: If an event input is high in the same cycle its service pulse is issued, the new assertion is kept, and it yields another pulse in the next cycle.
- R8: `wake_o` is high outside RUN whenever any event latch or the held bus interrupt is set, whatever the value of `core_if`. `wake_o` is low in RUN.
- R9: An `irq_captured` handshake accepted in SNOOP sets a held bus interrupt. In RUN, this held interrupt appears as a single `bus_irq_svc_o` pulse while `core_if` is high. It stays held while `core_if` is low.
- R10: `snoop_req` and `irq_txn_req` have no effect in RUN: the state stays RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| clk_stop_req | input | 1 | System request to stop the core clocks |
| core_rst_req | input | 1 | Core initialise request; the power state does not change |
| snoop_req | input | 1 | Bus snoop observed |
| irq_txn_req | input | 1 | Bus interrupt transaction observed |
| snoop_done | input | 1 | Snoop has been serviced |
| irq_captured | input | 1 | Bus interrupt has been captured |
| core_if | input | 1 | Core interrupt-enable flag |
| evt_in | input | 5 | Sideband event lines (see R5 for bit order) |
| state_o | output | 2 | Power state: 0 RUN, 1 GRANT, 2 SNOOP |
| svc_o | output | 5 | One-cycle service pulse for each event type |
| bus_irq_svc_o | output | 1 | Delivery pulse for the held bus interrupt |
| core_init_o | output | 1 | One-cycle core initialise pulse |
| wake_o | output | 1 | Pending-work indication while the core is stopped |

## Verification
The bench repeats the same event several times while the core is stopped and checks that only one pulse per type comes out on return. A design that counted the assertions instead of collapsing them would pulse repeatedly. The bench raises an event in its own service cycle; a latch that cleared without first looking at its input would lose that assertion and give no second pulse. The bench answers only half of a two-kind snoop detour, which catches a design that leaves SNOOP on any single handshake. It also withdraws the stop request while a snoop is requested in the same cycle, which shows whether the return to RUN has priority. Finally, it holds a captured bus interrupt with the enable flag cleared. Here it expects `wake_o` to be high while the core is stopped and no delivery while the core runs, so a wake output gated by the enable flag, or a delivery that ignores it, would be caught.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Number of sideband event lines and their positions in evt_in
    localparam int EVT_N     = 5;
    localparam int EVT_MGMT  = 0;
    localparam int EVT_SINIT = 1;
    localparam int EVT_BINIT = 2;
    localparam int EVT_LOC0  = 3;
    localparam int EVT_LOC1  = 4;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_GRANT = 2'd1,
        PS_SNOOP = 2'd2
    } pstate_e;

    // Outstanding work that keeps the controller in the snoop detour
    typedef struct packed {
        logic snoop;
        logic itx;
    } snp_pend_t;

    function automatic logic is_stopped(pstate_e s);
        return s != PS_RUN;
    endfunction

endpackage

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
    import clkstop_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stop_req,
    input  logic    snoop_req,
    input  logic    itx_req,
    input  logic    snoop_done,
    input  logic    itx_ack,
    output pstate_e state,
    output logic    itx_captured
);

    pstate_e   st_q, st_d;
    snp_pend_t pend_q, pend_d;

    always_comb begin
        st_d         = st_q;
        pend_d       = pend_q;
        itx_captured = 1'b0;
        unique case (st_q)
            PS_RUN: begin
                pend_d = '0;
                if (stop_req) st_d = PS_GRANT;
            end
            PS_GRANT: begin
                if (!stop_req) begin
                    st_d = PS_RUN;
                end else if (snoop_req || itx_req) begin
                    st_d         = PS_SNOOP;
                    pend_d.snoop = snoop_req;
                    pend_d.itx   = itx_req;
                end
            end
            PS_SNOOP: begin
                if (pend_q.snoop && snoop_done) pend_d.snoop = 1'b0;
                if (pend_q.itx && itx_ack) begin
                    pend_d.itx   = 1'b0;
                    itx_captured = 1'b1;
                end
                if (!pend_d.snoop && !pend_d.itx) st_d = PS_GRANT;
            end
            default: begin
                st_d   = PS_RUN;
                pend_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PS_RUN;
            pend_q <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    assign state = st_q;

    // R2: a stop request in RUN is granted on the next edge
    p_run_to_grant_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_RUN && stop_req) |=> (st_q == PS_GRANT));

    // R2: withdrawing the request in GRANT returns to RUN
    p_grant_exit_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_GRANT && !stop_req) |=> (st_q == PS_RUN));

    // R3: with no handshake the detour is held
    p_snoop_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_SNOOP && !snoop_done && !itx_ack) |=> (st_q == PS_SNOOP));

    // R10: bus requests in RUN without a stop request leave RUN alone
    p_run_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_RUN && !stop_req) |=> (st_q == PS_RUN));

endmodule

// File: rtl/clkstop_evt_bank.sv
module clkstop_evt_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] evt_in,
    output logic [W-1:0] svc,
    output logic         any_held
);

    logic [W-1:0] held_q;

    for (genvar i = 0; i < W; i++) begin : g_evt
        logic held;

        always_ff @(posedge clk) begin
            if (rst) held <= 1'b0;
            else     held <= (held & ~svc[i]) | evt_in[i];
        end

        assign held_q[i] = held;
        assign svc[i]    = run & held;

        // R6: a pulse with no fresh assertion is not repeated
        p_svc_once_r6: assert property (@(posedge clk) disable iff (rst)
            (svc[i] && !evt_in[i]) |=> !svc[i]);

        // R7: an assertion in the service cycle survives
        p_keep_new_r7: assert property (@(posedge clk) disable iff (rst)
            (svc[i] && evt_in[i]) |=> held_q[i]);

        // R5: any assertion is captured whatever the state
        p_capture_r5: assert property (@(posedge clk) disable iff (rst)
            evt_in[i] |=> held_q[i]);
    end

    assign any_held = |held_q;

    // R5: nothing is serviced while stopped
    p_quiet_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        !run |-> (svc == '0));

endmodule

// File: rtl/clkstop_side.sv
module clkstop_side (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic core_rst_req,
    input  logic itx_captured,
    input  logic core_if,
    input  logic any_evt_held,
    output logic core_init,
    output logic bus_irq_svc,
    output logic wake
);

    logic rst_req_q;
    logic init_q;
    logic bus_held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q  <= 1'b0;
            init_q     <= 1'b0;
            bus_held_q <= 1'b0;
        end else begin
            rst_req_q  <= core_rst_req;
            init_q     <= core_rst_req & ~rst_req_q;
            bus_held_q <= (bus_held_q & ~bus_irq_svc) | itx_captured;
        end
    end

    assign core_init   = init_q;
    assign bus_irq_svc = run & bus_held_q & core_if;
    // Masked interrupts still request a wake: core_if is not used here
    assign wake        = !run & (any_evt_held | bus_held_q);

    // R4: the initialise pulse is one cycle wide
    p_init_single_r4: assert property (@(posedge clk) disable iff (rst)
        core_init |=> !core_init);

    // R8: no wake indication while running
    p_wake_run_r8: assert property (@(posedge clk) disable iff (rst)
        run |-> !wake);

    // R9: a held bus interrupt is delivered once
    p_bus_svc_once_r9: assert property (@(posedge clk) disable iff (rst)
        bus_irq_svc |=> !bus_irq_svc);

endmodule

// File: rtl/clkstop_pwr_ctrl.sv
module clkstop_pwr_ctrl
    import clkstop_pkg::*;
#(
    parameter int EVT_W = EVT_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_stop_req,
    input  logic             core_rst_req,
    input  logic             snoop_req,
    input  logic             irq_txn_req,
    input  logic             snoop_done,
    input  logic             irq_captured,
    input  logic             core_if,
    input  logic [EVT_W-1:0] evt_in,
    output logic [1:0]       state_o,
    output logic [EVT_W-1:0] svc_o,
    output logic             bus_irq_svc_o,
    output logic             core_init_o,
    output logic             wake_o
);

    pstate_e st;
    logic    run;
    logic    itx_cap;
    logic    evt_any;

    clkstop_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .stop_req     (clk_stop_req),
        .snoop_req    (snoop_req),
        .itx_req      (irq_txn_req),
        .snoop_done   (snoop_done),
        .itx_ack      (irq_captured),
        .state        (st),
        .itx_captured (itx_cap)
    );

    assign run     = !is_stopped(st);
    assign state_o = st;

    clkstop_evt_bank #(.W(EVT_W)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .evt_in   (evt_in),
        .svc      (svc_o),
        .any_held (evt_any)
    );

    clkstop_side u_side (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .core_rst_req (core_rst_req),
        .itx_captured (itx_cap),
        .core_if      (core_if),
        .any_evt_held (evt_any),
        .core_init    (core_init_o),
        .bus_irq_svc  (bus_irq_svc_o),
        .wake         (wake_o)
    );

    // R4: an initialise pulse seen in GRANT with the request still high leaves the state alone
    p_init_no_move_r4: assert property (@(posedge clk) disable iff (rst)
        (core_init_o && st == PS_GRANT && clk_stop_req && !snoop_req && !irq_txn_req)
            |=> (st == PS_GRANT));

endmodule

// File: tb/test_clkstop_pwr_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_pwr_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       clk_stop_req, core_rst_req, snoop_req, irq_txn_req;
    logic       snoop_done, irq_captured, core_if;
    logic [4:0] evt_in;
    logic [1:0] state_o;
    logic [4:0] svc_o;
    logic       bus_irq_svc_o, core_init_o, wake_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    clkstop_pwr_ctrl i_clkstop_pwr_ctrl (
        .clk           (clk),
        .rst           (rst),
        .clk_stop_req  (clk_stop_req),
        .core_rst_req  (core_rst_req),
        .snoop_req     (snoop_req),
        .irq_txn_req   (irq_txn_req),
        .snoop_done    (snoop_done),
        .irq_captured  (irq_captured),
        .core_if       (core_if),
        .evt_in        (evt_in),
        .state_o       (state_o),
        .svc_o         (svc_o),
        .bus_irq_svc_o (bus_irq_svc_o),
        .core_init_o   (core_init_o),
        .wake_o        (wake_o)
    );

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; clk_stop_req = 0; core_rst_req = 0; snoop_req = 0;
        irq_txn_req = 0; snoop_done = 0; irq_captured = 0; core_if = 0; evt_in = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1", "state", state_o, 0);
        chk("R1", "svc", svc_o, 0);
        chk("R1", "wake", wake_o, 0);
        chk("R1", "init", core_init_o, 0);
        chk("R1", "bus svc", bus_irq_svc_o, 0);
    endtask

    task automatic t_enter_exit();
        clk_stop_req = 1; tick();
        chk("R2", "enter grant", state_o, 1);
        clk_stop_req = 0; snoop_req = 1; tick();
        chk("R2", "exit wins over snoop", state_o, 0);
        irq_txn_req = 1; tick();
        chk("R10", "run ignores bus", state_o, 0);
        snoop_req = 0; irq_txn_req = 0;
    endtask

    task automatic t_snoop();
        clk_stop_req = 1; tick();
        snoop_req = 1; irq_txn_req = 1; tick();
        chk("R3", "enter snoop", state_o, 2);
        snoop_req = 0; irq_txn_req = 0; tick(); tick();
        chk("R3", "held in snoop", state_o, 2);
        snoop_done = 1; tick();
        chk("R3", "half answered", state_o, 2);
        snoop_done = 0; irq_captured = 1; tick();
        chk("R3", "back to grant", state_o, 1);
        irq_captured = 0;
        chk("R8", "wake masked irq", wake_o, 1);
        tick();
        chk("R8", "wake holds", wake_o, 1);
        clk_stop_req = 0; tick();
        chk("R9", "state run", state_o, 0);
        chk("R9", "masked not delivered", bus_irq_svc_o, 0);
        chk("R8", "wake low in run", wake_o, 0);
        tick();
        chk("R9", "still held", bus_irq_svc_o, 0);
        core_if = 1; #1;
        chk("R9", "delivered", bus_irq_svc_o, 1);
        tick();
        chk("R9", "delivered once", bus_irq_svc_o, 0);
        core_if = 0;
    endtask

    task automatic t_core_init();
        clk_stop_req = 1; tick();
        core_rst_req = 1; tick();
        chk("R4", "init pulse", core_init_o, 1);
        chk("R4", "state kept", state_o, 1);
        tick();
        chk("R4", "pulse ends", core_init_o, 0);
        chk("R4", "state kept later", state_o, 1);
        core_rst_req = 0; clk_stop_req = 0; tick();
        chk("R2", "exit after init", state_o, 0);
    endtask

    task automatic t_collapse();
        clk_stop_req = 1; tick();
        for (int k = 0; k < 3; k++) begin
            evt_in = 5'b00001; tick();
            chk("R5", "no svc stopped", svc_o, 0);
            evt_in = '0; tick();
        end
        evt_in = 5'b00100; tick();
        evt_in = '0; tick();
        chk("R5", "bus init held", svc_o, 0);
        chk("R8", "wake from events", wake_o, 1);
        chk("R5", "still grant", state_o, 1);
        clk_stop_req = 0; tick();
        chk("R6", "state run", state_o, 0);
        chk("R6", "one pulse each", svc_o, 5'b00101);
        chk("R8", "wake low", wake_o, 0);
        tick();
        chk("R6", "pulse ends", svc_o, 0);
    endtask

    task automatic t_keep();
        clk_stop_req = 1; tick();
        evt_in = 5'b01000; tick();
        evt_in = '0; tick();
        clk_stop_req = 0; tick();
        chk("R6", "first pulse", svc_o, 5'b01000);
        evt_in = 5'b01000; tick();
        chk("R7", "kept assertion", svc_o, 5'b01000);
        evt_in = '0; tick();
        chk("R7", "then quiet", svc_o, 0);
        evt_in = 5'b10000; tick();
        chk("R6", "run event", svc_o, 5'b10000);
        evt_in = '0; tick();
        chk("R6", "run event once", svc_o, 0);
    endtask

    initial begin
        t_reset();
        t_enter_exit();
        t_snoop();
        t_core_init();
        t_collapse();
        t_keep();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule